// File: doc/BRIEF.md
# Oscillator Warm-Up Timer

This block measures a programmable settling interval after software turns on an oscillator that was stopped. An arming edge on either of two oscillator enable bits clears a 14-stage counter and starts it. The counter advances from strobes of a selected source, thinned by a power-of-two prescaler. When the top eight counter stages reach the programmed warm-up value, the block emits a one-cycle interrupt, stops and clears itself.

All logic runs on a single system clock. The two oscillators appear as one-cycle strobes, a fast one and a slow one. Software reaches the block through a small write port with two addresses. The enable bits are returned on outputs so that the clock-control logic beside the block can read them. A self-clearing abort bit halts a warm-up in progress and leaves both enable bits as they were. To start another warm-up, software must first drop an enable bit to 0 and then raise it again.

Top module: `osc_warmup_timer`

## Requirements
- R1: After reset, irq, busy, fast_en and slow_en are all 0.
- R2: The port has two addresses. A write to address 0 loads the control byte: bit 0 is the source select (0 = fast strobe, 1 = slow strobe), bits 2:1 are the divider code n, bit 3 is abort, bit 4 is the fast enable and bit 5 is the slow enable. A write to address 1 loads the 8-bit warm-up value k. The enable outputs show the written bits from the cycle after the write edge.
- R3: Only a 0-to-1 change of fast_en or slow_en arms the timer. Writing 1 to an enable bit that already holds 1 leaves busy low and produces no irq.
- R4: busy rises on the clock edge after the edge that registers an arming write. It stays high until the compare match or an abort.
- R5: The counter advances once for every 2^n strobes of the selected source. Strobes from the other source have no effect.
- R6: With k ≥ 1, irq is asserted after exactly k·64·2^n selected strobes counted while busy. The interrupt lasts one cycle, and busy is low in that same cycle.
- R7: With k = 0, irq is asserted after exactly 2^n selected strobes, on the first counter advance.
- R8: Writing abort drops busy on the next edge, clears the counter and raises no irq. The enable bits keep their values, and abort clears itself. A warm-up armed after an abort takes its full time.
- R9: When a single control write both sets abort and raises an enable bit from 0 to 1, the abort takes precedence: busy stays low and no irq follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 1 | Register address (0 = control, 1 = warm-up value) |
| wr_data | input | 8 | Write data |
| fast_tick | input | 1 | One-cycle strobe from the fast oscillator |
| slow_tick | input | 1 | One-cycle strobe from the slow oscillator |
| irq | output | 1 | Warm-up complete, one-cycle pulse |
| busy | output | 1 | A warm-up is in progress |
| fast_en | output | 1 | Read-back of the fast oscillator enable |
| slow_en | output | 1 | Read-back of the slow oscillator enable |

## Verification
The hardest cases to reach from the ports are those where the enable history and the write contents conflict. One is a write of 1 to an enable bit that is already set, which must not re-arm the timer. The other is a single write that carries both abort and a rising enable. The bench reaches the first by completing a warm-up and then writing the same control byte again. It reaches the second by clearing the enables, then sending a single byte that holds abort together with a new enable. In both cases it then feeds a long run of strobes and watches busy and irq. The bench also sweeps the full timing grid of source, divider code and small warm-up values. It runs the largest warm-up value once and checks the strobe count of each run against k·64·2^n.

// File: rtl/wut_pkg.sv
package wut_pkg;
  parameter int CMP_W  = 8;
  parameter int CNT_W  = 14;
  parameter int DIV_W  = 2;
  parameter int NSRC   = 2;
  parameter int ADDR_W = 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 1'b1;

  localparam int BIT_SRC   = 0;
  localparam int BIT_DIV   = 1;
  localparam int BIT_ABORT = BIT_DIV + DIV_W;
  localparam int BIT_EN    = BIT_ABORT + 1;

  typedef struct packed {
    logic             src_sel;
    logic [DIV_W-1:0] div_sel;
    logic [CMP_W-1:0] cmp;
  } wut_cfg_t;
endpackage

// File: rtl/wut_regs.sv
module wut_regs
  import wut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMP_W-1:0]  wr_data,
  output wut_cfg_t          cfg,
  output logic [NSRC-1:0]   en,
  output logic              arm_p,
  output logic              abort_p
);
  wut_cfg_t          cfg_q, cfg_nxt;
  logic [NSRC-1:0]   en_q, en_nxt;
  logic [NSRC-1:0]   hist_q;
  logic [NSRC-1:0]   rise;
  logic              abort_q, abort_nxt;
  logic              ctrl_wr, cmp_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign cmp_wr  = wr_en && (wr_addr == ADDR_CMP);

  always_comb begin
    cfg_nxt   = cfg_q;
    en_nxt    = en_q;
    abort_nxt = 1'b0;
    if (ctrl_wr) begin
      cfg_nxt.src_sel = wr_data[BIT_SRC];
      cfg_nxt.div_sel = wr_data[BIT_DIV +: DIV_W];
      en_nxt          = wr_data[BIT_EN +: NSRC];
      abort_nxt       = wr_data[BIT_ABORT];
    end
    if (cmp_wr) begin
      cfg_nxt.cmp = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      en_q    <= '0;
      hist_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_nxt;
      en_q    <= en_nxt;
      hist_q  <= en_q;
      abort_q <= abort_nxt;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_edge
    assign rise[g] = en_q[g] & ~hist_q[g];
  end

  assign cfg     = cfg_q;
  assign en      = en_q;
  assign arm_p   = |rise;
  assign abort_p = abort_q;
endmodule

// File: rtl/wut_prescale.sv
module wut_prescale
  import wut_pkg::*;
#(
  parameter int PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [NSRC-1:0]  tick_src,
  output logic             adv
);
  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic [PRE_W-1:0] mask;
  logic             sel_tick;
  logic             wrap;

  assign sel_tick = tick_src[src_sel];

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(div_sel)) mask[i] = 1'b1;
    end
  end

  assign wrap = (pre_q == mask);
  assign adv  = run && sel_tick && wrap;

  always_comb begin
    pre_nxt = pre_q;
    if (!run) begin
      pre_nxt = '0;
    end else if (sel_tick) begin
      pre_nxt = wrap ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nxt;
  end
endmodule

// File: rtl/wut_core.sv
module wut_core
  import wut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_p,
  input  logic             abort_p,
  input  logic             adv,
  input  logic [CMP_W-1:0] cmp,
  output logic             busy,
  output logic             irq
);
  localparam int LOW_W = CNT_W - CMP_W;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_inc;
  logic             busy_q, busy_nxt;
  logic             irq_q, irq_nxt;
  logic             hit;

  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = (cnt_inc[LOW_W +: CMP_W] == cmp);

  always_comb begin
    cnt_nxt  = cnt_q;
    busy_nxt = busy_q;
    irq_nxt  = 1'b0;
    if (abort_p) begin
      cnt_nxt  = '0;
      busy_nxt = 1'b0;
    end else if (arm_p) begin
      cnt_nxt  = '0;
      busy_nxt = 1'b1;
    end else if (busy_q && adv) begin
      if (hit) begin
        cnt_nxt  = '0;
        busy_nxt = 1'b0;
        irq_nxt  = 1'b1;
      end else begin
        cnt_nxt = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      busy_q <= busy_nxt;
      irq_q  <= irq_nxt;
    end
  end

  assign busy = busy_q;
  assign irq  = irq_q;
endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer
  import wut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMP_W-1:0]  wr_data,
  input  logic              fast_tick,
  input  logic              slow_tick,
  output logic              irq,
  output logic              busy,
  output logic              fast_en,
  output logic              slow_en
);
  wut_cfg_t        cfg;
  logic [NSRC-1:0] en;
  logic            arm_p;
  logic            abort_p;
  logic            adv;
  logic            busy_i;

  wut_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg),
    .en      (en),
    .arm_p   (arm_p),
    .abort_p (abort_p)
  );

  wut_prescale u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_i),
    .src_sel  (cfg.src_sel),
    .div_sel  (cfg.div_sel),
    .tick_src ({slow_tick, fast_tick}),
    .adv      (adv)
  );

  wut_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_p   (arm_p),
    .abort_p (abort_p),
    .adv     (adv),
    .cmp     (cfg.cmp),
    .busy    (busy_i),
    .irq     (irq)
  );

  assign busy    = busy_i;
  assign fast_en = en[0];
  assign slow_en = en[1];
endmodule

// File: rtl/wut_checker.sv
module wut_checker (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic busy,
  input logic arm_p,
  input logic abort_p,
  input logic adv,
  input logic fast_en,
  input logic slow_en
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R6
  AST_IRQ_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !busy); // R6
  AST_IRQ_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ($past(busy) && $past(adv))); // R5
  AST_BUSY_ONLY_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(arm_p)); // R3
  AST_ARM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (arm_p && !abort_p) |=> busy); // R4
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n) abort_p |=> (!busy && !irq)); // R9
  AST_ABORT_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) abort_p |=> !abort_p); // R8
  AST_ABORT_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n) abort_p |=> ($stable(fast_en) && $stable(slow_en))); // R8
endmodule

bind osc_warmup_timer wut_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .busy    (busy),
  .arm_p   (arm_p),
  .abort_p (abort_p),
  .adv     (adv),
  .fast_en (fast_en),
  .slow_en (slow_en)
);

// File: tb/sim_osc_warmup_timer.sv
`timescale 1ns/1ps
module sim_osc_warmup_timer;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [0:0] wr_addr;
  logic [7:0] wr_data;
  logic       fast_tick;
  logic       slow_tick;
  logic       irq, busy, fast_en, slow_en;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done_flag = 0;

  osc_warmup_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .irq(irq), .busy(busy), .fast_en(fast_en), .slow_en(slow_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done_flag) begin
      done_flag = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl(input bit src, input int div, input bit abort,
                                      input bit fen, input bit sen);
    return {2'b00, sen, fen, abort, div[1:0], src};
  endfunction

  task automatic wr(input bit addr, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // feeds strobes until irq; fast strobe every cycle, slow strobe every other
  // cycle; the unselected source keeps strobing too and must be ignored (R5)
  task automatic run_to_irq(input bit src, output longint cnt, output bit seen);
    int ph = 0;
    cnt = 0;
    seen = 0;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (irq) begin
        seen = 1;
        break;
      end
      fast_tick = 1'b1;
      slow_tick = ph[0];
      if (src == 1'b0) cnt++;
      else if (ph[0]) cnt++;
      ph++;
    end
    fast_tick = 1'b0;
    slow_tick = 1'b0;
  endtask

  task automatic wait_busy(output bit ok);
    ok = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy) begin ok = 1; break; end
    end
  endtask

  task automatic strobes_no_irq(input int n, output bit saw);
    saw = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq || busy) saw = 1;
      fast_tick = 1'b1; slow_tick = 1'b1;
    end
    @(negedge clk);
    if (irq || busy) saw = 1;
    fast_tick = 1'b0; slow_tick = 1'b0;
  endtask

  task automatic one_run(input bit src, input int div, input int k, input string tag);
    longint cnt; bit seen; bit b; longint exp;
    exp = (k == 0) ? (64'd1 << div) : longint'(k) * 64 * (64'd1 << div);
    wr(1'b1, 8'(k));
    wr(1'b0, ctrl(src, div, 0, 0, 0));
    wr(1'b0, ctrl(src, div, 0, 1, 0));
    wait_busy(b);
    check(b, {tag, " busy after arm R4"}, b, 1);
    run_to_irq(src, cnt, seen);
    check(seen && cnt == exp, tag, cnt, exp);
    check(!busy, {tag, " busy low at irq R6"}, busy, 0);
    @(negedge clk);
    check(!irq, {tag, " irq single cycle R6"}, irq, 0);
  endtask

  initial begin
    longint cnt; bit seen; bit b; bit saw;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    fast_tick = 1'b0; slow_tick = 1'b0;
    idle(3);
    check(!irq && !busy && !fast_en && !slow_en, "R1 reset state",
          {irq, busy, fast_en, slow_en}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 enable readback
    wr(1'b0, ctrl(0, 0, 0, 0, 1));
    check(slow_en && !fast_en, "R2 enable readback", {slow_en, fast_en}, 2);
    wr(1'b0, ctrl(0, 0, 0, 0, 0));
    idle(3);

    // R5 R6 R7 sweep: both sources, all divider codes, small warm-up values
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 4; d++)
        for (int k = 0; k < 3; k++)
          one_run(s[0], d, k, (k == 0) ? "R7 zero value timing" : "R6 warm-up timing");

    // R6 largest value
    one_run(1'b0, 0, 255, "R6 max value timing");

    // R3 rewrite 1 to an enable already at 1
    wr(1'b0, ctrl(0, 0, 0, 1, 0));
    strobes_no_irq(200, saw);
    check(!saw, "R3 rewrite of set enable does not arm", saw, 0);

    // R3 arming by the slow enable edge while fast stays set
    wr(1'b1, 8'd1);
    wr(1'b0, ctrl(0, 0, 0, 1, 1));
    wait_busy(b);
    check(b, "R3 slow enable edge arms", b, 1);
    run_to_irq(1'b0, cnt, seen);
    check(seen && cnt == 64, "R3 slow-armed warm-up timing", cnt, 64);

    // R8 abort in the middle of a warm-up
    wr(1'b0, ctrl(0, 0, 0, 0, 0));
    wr(1'b0, ctrl(0, 0, 0, 1, 0));
    wait_busy(b);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); fast_tick = 1'b1;
    end
    @(negedge clk); fast_tick = 1'b0;
    wr(1'b0, ctrl(0, 0, 1, 1, 0));
    @(negedge clk);
    check(!busy, "R8 abort drops busy", busy, 0);
    check(fast_en && !slow_en, "R8 abort keeps enables", {slow_en, fast_en}, 1);
    strobes_no_irq(200, saw);
    check(!saw, "R8 no irq after abort", saw, 0);
    wr(1'b0, ctrl(0, 0, 0, 0, 0));
    wr(1'b0, ctrl(0, 0, 0, 1, 0));
    wait_busy(b);
    run_to_irq(1'b0, cnt, seen);
    check(seen && cnt == 64, "R8 full time after abort", cnt, 64);

    // R9 abort and arming edge in one write
    wr(1'b0, ctrl(0, 0, 0, 0, 0));
    wr(1'b0, ctrl(0, 0, 1, 1, 0));
    check(fast_en, "R9 enable written with abort", fast_en, 1);
    strobes_no_irq(200, saw);
    check(!saw, "R9 abort wins over arming edge", saw, 0);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule